// File: doc/BRIEF.md
# Serial Banked Register Target

This block is the slave end of a four-wire serial link in clock/data mode 0. It gives a host access to a banked 32-bit register space. It oversamples the serial clock, chip select and data-in with its own system clock. Each frame begins with two header bytes. The first is a command byte that packs a bank number, a direction bit and a sub-bank number. The second is the register index. After the header the frame carries either four write-data bytes, or two padding bytes followed by four read-data bytes that the block drives out.

The register space itself sits outside the block, behind a parallel port that carries a registered address, a one-cycle write strobe with write data, and a combinational read-data input. A hardware table of legal bank/sub-bank pairs guards every access. An access to an illegal pair never reaches the port, returns zeros on a read, and sets a sticky error flag. One identification register is held inside the block: bank 7, sub-bank 0, index 0x18.

Top module: `spi_regtarget`

## Requirements
- R1: Data-in is sampled on rising serial-clock edges and data-out changes on falling edges. All bytes are MSB first. In a read frame, bytes 3 and 4 are padding and bytes 5 to 8 return the 32-bit register, most significant byte first.
- R2: A write frame raises `reg_we` for exactly one cycle, and only after all 32 data bits have been received. `reg_wdata` then holds the four data bytes, first byte in bits 31:24.
- R3: Command byte fields: bits 7:5 select the bank, bit 4 is the direction (1 = write, 0 = read) and bits 3:0 select the sub-bank. `reg_addr` is {bank[14:12], sub-bank[11:8], index[7:0]}.
- R4: The legal pairs are: bank 1 with sub-bank 0 to 4 or 6; banks 2 and 7 with sub-bank 0; banks 3, 4 and 5 with sub-bank 0 or 1. A write to any other pair raises no strobe.
- R5: A read of an illegal pair returns 32'h00000000. A read of a legal pair returns the `reg_rdata` value presented for its address.
- R6: `err_flag` rises after the header of any illegal access. It stays high until `rst`.
- R7: A read of bank 7, sub-bank 0, index 0x18 returns {REV[31:28], DEV_CODE[27:12], 12'h000} (default 32'h35A3C000). A write to that address raises no strobe.
- R8: Raising `cs_n` at any point, including mid-byte, ends the frame without a strobe. The next frame is decoded from its first bit.
- R9: While `rst` is high and just after it, `reg_we`, `miso` and `err_flag` are 0.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low frame select |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host, 0 when idle |
| reg_addr | output | 15 | Bank, sub-bank and index of the current frame |
| reg_we | output | 1 | One-cycle write strobe |
| reg_wdata | output | 32 | Write data |
| reg_rdata | input | 32 | Read data for `reg_addr` |
| err_flag | output | 1 | Sticky illegal-access flag |

## Verification
The bench reads every bank with sub-bank 0 to 7 plus 15, which walks the whole legality table. A wrong table entry would return port data where zeros were due, or the reverse. The bench also aborts frames two data bytes short and three bits into a byte. A design that strobed early or kept stale bit counts would emit a spurious write, or misframe the legal write that follows. Writes to the identification register and to illegal pairs are compared against the bench model's expected-write queue on every clock, so a leaked strobe appears at once. A reset in the middle of the run confirms that the error flag clears on reset and on nothing else.

// File: rtl/spi_rt_pkg.sv
package spi_rt_pkg;
    localparam int BYTE_W   = 8;
    localparam int WORD_W   = 32;
    localparam int ADDR_W   = 15;
    localparam int HDR_N    = 2;
    localparam int PAD_N    = 2;
    localparam int WORD_N   = WORD_W / BYTE_W;
    localparam int FRAME_N  = HDR_N + PAD_N + WORD_N;
    localparam logic [2:0] ID_BANK = 3'd7;
    localparam logic [3:0] ID_SUB  = 4'd0;
    localparam logic [7:0] ID_IDX  = 8'h18;

    typedef struct packed {
        logic [2:0] bank;
        logic       wr;
        logic [3:0] sub;
    } cmd_t;

    function automatic logic pair_ok(input logic [2:0] bank, input logic [3:0] sub);
        case (bank)
            3'd1:             return (sub <= 4'd4) || (sub == 4'd6);
            3'd2, 3'd7:       return sub == 4'd0;
            3'd3, 3'd4, 3'd5: return sub <= 4'd1;
            default:          return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/spi_rt_sync.sv
module spi_rt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk,
    input  logic cs_n,
    input  logic mosi,
    output logic rise,
    output logic fall,
    output logic cs_act,
    output logic mosi_s
);
    logic [STAGES-1:0] sck_p, cs_p, mo_p;
    logic sck_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_p    <= '0;
            cs_p     <= '1;
            mo_p     <= '0;
            sck_last <= 1'b0;
        end else begin
            sck_p    <= {sck_p[STAGES-2:0], sclk};
            cs_p     <= {cs_p[STAGES-2:0], cs_n};
            mo_p     <= {mo_p[STAGES-2:0], mosi};
            sck_last <= sck_p[STAGES-1];
        end
    end

    assign cs_act = ~cs_p[STAGES-1];
    assign mosi_s = mo_p[STAGES-1];
    assign rise   = cs_act & sck_p[STAGES-1] & ~sck_last;
    assign fall   = cs_act & ~sck_p[STAGES-1] & sck_last;
endmodule

// File: rtl/spi_rt_frame.sv
module spi_rt_frame
    import spi_rt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rise,
    input  logic              cs_act,
    input  logic              mosi_s,
    output cmd_t              cmd,
    output logic [BYTE_W-1:0] idx,
    output logic              hdr_done,
    output logic              wr_done,
    output logic [WORD_W-1:0] wdata,
    output logic [3:0]        byte_idx
);
    localparam int LAST_BIT = BYTE_W - 1;

    logic [2:0]        bit_q;
    logic [BYTE_W-1:0] sh_q;
    logic [BYTE_W-1:0] nxt;
    logic              in_data;

    assign nxt     = {sh_q[BYTE_W-2:0], mosi_s};
    assign in_data = cmd.wr && byte_idx >= 4'(HDR_N) && byte_idx < 4'(HDR_N + WORD_N);

    always_ff @(posedge clk) begin
        hdr_done <= 1'b0;
        wr_done  <= 1'b0;
        if (rst || !cs_act) begin
            bit_q    <= '0;
            byte_idx <= '0;
            sh_q     <= '0;
            if (rst) begin
                cmd   <= '0;
                idx   <= '0;
                wdata <= '0;
            end
        end else if (rise && byte_idx < 4'(FRAME_N)) begin
            sh_q  <= nxt;
            bit_q <= bit_q + 3'd1;
            if (in_data) wdata <= {wdata[WORD_W-2:0], mosi_s};
            if (bit_q == 3'(LAST_BIT)) begin
                byte_idx <= byte_idx + 4'd1;
                if (byte_idx == 4'd0) cmd <= cmd_t'(nxt);
                if (byte_idx == 4'd1) begin
                    idx      <= nxt;
                    hdr_done <= 1'b1;
                end
                if (cmd.wr && byte_idx == 4'(HDR_N + WORD_N - 1)) wr_done <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/spi_rt_tx.sv
module spi_rt_tx
    import spi_rt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fall,
    input  logic              cs_act,
    input  logic              load,
    input  logic [WORD_W-1:0] load_val,
    input  logic [3:0]        byte_idx,
    output logic              miso
);
    logic [WORD_W-1:0] tx_q;
    logic              armed_q, out_q;
    logic              in_win;

    assign in_win = byte_idx >= 4'(HDR_N + PAD_N) && byte_idx < 4'(FRAME_N);

    always_ff @(posedge clk) begin
        if (rst || !cs_act) begin
            tx_q    <= '0;
            armed_q <= 1'b0;
            out_q   <= 1'b0;
        end else if (load) begin
            tx_q    <= load_val;
            armed_q <= 1'b1;
            out_q   <= 1'b0;
        end else if (fall && armed_q && in_win) begin
            if (!out_q) out_q <= 1'b1;
            else        tx_q  <= {tx_q[WORD_W-2:0], 1'b0};
        end
    end

    assign miso = out_q & tx_q[WORD_W-1];
endmodule

// File: rtl/spi_regtarget.sv
module spi_regtarget
    import spi_rt_pkg::*;
#(
    parameter logic [15:0] DEV_CODE    = 16'h5A3C,
    parameter logic [3:0]  REV         = 4'h3,
    parameter int          SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              mosi,
    output logic              miso,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_we,
    output logic [WORD_W-1:0] reg_wdata,
    input  logic [WORD_W-1:0] reg_rdata,
    output logic              err_flag
);
    localparam logic [WORD_W-1:0] ID_WORD = {REV, DEV_CODE, 12'h000};

    logic              rise, fall, cs_act, mosi_s;
    cmd_t              cmd;
    logic [BYTE_W-1:0] idx;
    logic              hdr_done, wr_done;
    logic [3:0]        byte_idx;
    logic              legal, is_id, load;
    logic [WORD_W-1:0] rd_val;

    spi_rt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .rise(rise), .fall(fall), .cs_act(cs_act), .mosi_s(mosi_s)
    );

    spi_rt_frame u_frame (
        .clk(clk), .rst(rst), .rise(rise), .cs_act(cs_act), .mosi_s(mosi_s),
        .cmd(cmd), .idx(idx), .hdr_done(hdr_done), .wr_done(wr_done),
        .wdata(reg_wdata), .byte_idx(byte_idx)
    );

    assign reg_addr = {cmd.bank, cmd.sub, idx};
    assign legal    = pair_ok(cmd.bank, cmd.sub);
    assign is_id    = cmd.bank == ID_BANK && cmd.sub == ID_SUB && idx == ID_IDX;
    assign load     = hdr_done && !cmd.wr;
    assign rd_val   = !legal ? '0 : (is_id ? ID_WORD : reg_rdata);

    spi_rt_tx u_tx (
        .clk(clk), .rst(rst), .fall(fall), .cs_act(cs_act), .load(load),
        .load_val(rd_val), .byte_idx(byte_idx), .miso(miso)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_we   <= 1'b0;
            err_flag <= 1'b0;
        end else begin
            reg_we <= wr_done && legal && !is_id && cs_act;
            if (hdr_done && !legal) err_flag <= 1'b1;
        end
    end
endmodule

// File: rtl/spi_rt_chk.sv
module spi_rt_chk
    import spi_rt_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              err_flag,
    input logic              cs_act
);
    // R2
    we_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> !reg_we);
    // R4
    we_legal_chk: assert property (@(posedge clk) disable iff (rst)
        reg_we |-> pair_ok(reg_addr[14:12], reg_addr[11:8]));
    // R7
    we_not_id_chk: assert property (@(posedge clk) disable iff (rst)
        reg_we |-> (reg_addr != {ID_BANK, ID_SUB, ID_IDX}));
    // R6
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err_flag |=> err_flag);
    // R8
    we_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
        reg_we |-> $past(cs_act));
endmodule

bind spi_regtarget spi_rt_chk u_chk (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .err_flag(err_flag), .cs_act(cs_act)
);

// File: tb/sim_spi_regtarget.sv
module sim_spi_regtarget;
    localparam int HALF = 6;
    localparam logic [31:0] ID_EXP = 32'h35A3C000;

    logic clk = 1'b0, rst = 1'b1, sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso, reg_we, err_flag;
    logic [14:0] reg_addr;
    logic [31:0] reg_wdata, reg_rdata;

    int checks = 0, errors = 0;
    logic [46:0] exp_q[$];
    bit model_err = 0;
    bit done = 0;

    always #10 clk = ~clk;

    assign reg_rdata = {1'b1, reg_addr, ~reg_addr[7:0], 8'h3C};

    spi_regtarget u0 (
        .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .miso(miso), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .err_flag(err_flag)
    );

    function automatic bit ok_pair(input int b, input int s);
        if (b == 1) return (s <= 4) || (s == 6);
        if (b == 2 || b == 7) return s == 0;
        if (b >= 3 && b <= 5) return s <= 1;
        return 0;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // per-clock comparison of write strobes against the model queue (R2, R3, R4, R7)
    always @(negedge clk) begin
        if (!rst && reg_we) begin
            if (exp_q.size() == 0) chk(0, "R4/R7 unexpected strobe", {17'd0, reg_addr, reg_wdata}, 64'd0);
            else begin
                logic [46:0] e;
                e = exp_q.pop_front();
                chk({reg_addr, reg_wdata} == e, "R2/R3 write", {17'd0, reg_addr, reg_wdata}, {17'd0, e});
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            mosi = tx[i];
            idle(HALF);
            sclk = 1'b1;
            rx[i] = miso;
            idle(HALF);
            sclk = 1'b0;
        end
    endtask

    task automatic frame_start();
        cs_n = 1'b0;
        idle(HALF);
    endtask

    task automatic frame_end();
        idle(HALF);
        cs_n = 1'b1;
        idle(8);
    endtask

    task automatic do_write(input int b, input int s, input logic [7:0] r, input logic [31:0] d);
        logic [7:0] rx;
        if (ok_pair(b, s) && !(b == 7 && s == 0 && r == 8'h18))
            exp_q.push_back({3'(b), 4'(s), r, d});
        if (!ok_pair(b, s)) model_err = 1;
        frame_start();
        xfer({3'(b), 1'b1, 4'(s)}, rx);
        xfer(r, rx);
        for (int k = 3; k >= 0; k--) xfer(d[k*8 +: 8], rx);
        frame_end();
        chk(exp_q.size() == 0, "R2 strobe count", 64'(exp_q.size()), 64'd0);
        chk(err_flag == model_err, "R6 error flag", 64'(err_flag), 64'(model_err));
    endtask

    task automatic do_read(input int b, input int s, input logic [7:0] r, input string req);
        logic [7:0] rx;
        logic [31:0] got, exp;
        logic [14:0] a;
        a = {3'(b), 4'(s), r};
        if (!ok_pair(b, s)) begin exp = 32'h0; model_err = 1; end
        else if (b == 7 && s == 0 && r == 8'h18) exp = ID_EXP;
        else exp = {1'b1, a, ~a[7:0], 8'h3C};
        frame_start();
        xfer({3'(b), 1'b0, 4'(s)}, rx);
        xfer(r, rx);
        xfer(8'h00, rx);
        xfer(8'h00, rx);
        for (int k = 3; k >= 0; k--) begin
            xfer(8'h00, rx);
            got[k*8 +: 8] = rx;
        end
        frame_end();
        chk(got == exp, req, 64'(got), 64'(exp));
        chk(err_flag == model_err, "R6 error flag", 64'(err_flag), 64'(model_err));
    endtask

    initial begin
        logic [7:0] rx;
        idle(3);
        chk(reg_we == 0 && miso == 0 && err_flag == 0, "R9 in reset", {61'd0, reg_we, miso, err_flag}, 64'd0);
        rst = 1'b0;
        idle(2);
        chk(reg_we == 0 && miso == 0 && err_flag == 0, "R9 after reset", {61'd0, reg_we, miso, err_flag}, 64'd0);

        do_write(1, 6, 8'h19, 32'hA1B2C3D4);               // R2 R3
        do_write(3, 1, 8'h02, 32'h80000001);
        do_read(1, 2, 8'h50, "R1 read");                   // R1 R5
        do_read(7, 0, 8'h05, "R1 read sys");
        do_read(7, 0, 8'h18, "R7 id word");
        do_write(7, 0, 8'h18, 32'hFFFFFFFF);               // R7 no strobe
        do_read(1, 5, 8'h00, "R5 illegal read");           // sets R6
        do_write(2, 1, 8'h33, 32'h12345678);               // R4 no strobe
        for (int b = 0; b < 8; b++)
            for (int s = 0; s < 9; s++)
                do_read(b, (s == 8) ? 15 : s, 8'(b * 16 + s), "R4 table read");

        // R8: abort after two data bytes
        frame_start();
        xfer(8'h30, rx); xfer(8'h01, rx); xfer(8'hDE, rx); xfer(8'hAD, rx);
        frame_end();
        chk(exp_q.size() == 0, "R8 abort no strobe", 64'(exp_q.size()), 64'd0);
        // R8: abort mid-byte
        frame_start();
        for (int i = 0; i < 3; i++) begin
            mosi = 1'b1; idle(HALF); sclk = 1'b1; idle(HALF); sclk = 1'b0;
        end
        frame_end();
        do_write(4, 0, 8'h7E, 32'h0F0F55AA);               // R8 recovery
        do_read(4, 1, 8'h01, "R8 read after abort");

        rst = 1'b1; idle(2); rst = 1'b0; model_err = 0; idle(2);
        chk(err_flag == 0, "R6 cleared by reset", 64'(err_flag), 64'd0);
        do_write(5, 1, 8'hC0, 32'h00000000);
        do_read(2, 0, 8'hFF, "R1 read after reset");
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (190000) @(posedge clk);
                chk(0, "watchdog", 64'd0, 64'd1);
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule